// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a serial stream of data bits into a line level in one of eight line codes. It runs on a clock at twice the bit rate, so every bit cell lasts two clocks: a first half and a second half. A one-clock strobe marks the first half of each cell. In the cycle of that strobe the block captures the data bit and the 3-bit code selector. The line level changes on the clock edge that ends the strobe cycle, and again, where the code calls for it, on the next edge.

The transition-based codes depend on history. The block keeps the current line level. For the differential biphase code it also keeps the direction of the last mid-cell edge. The selector is taken only at cell starts, so software or a neighbouring block may change it at any time without making a broken cell. Clock generation and receive-side decoding belong to other blocks, and the receive side chooses its own code independently.

Top module: `lineEncoderTop`

## Requirements
- R1: A synchronous active-high reset drives `lineOut` low and sets the stored last mid-cell edge to falling.
- R2: With `modeSel`=0 the line equals the captured bit for both halves of the cell. With `modeSel`=1 it equals the inverted bit for both halves.
- R3: With `modeSel`=2 the line inverts at the cell start for a 1 and keeps its level for a 0. The second half repeats the first.
- R4: With `modeSel`=3 the line keeps its level at the cell start for a 1 and inverts for a 0. The second half repeats the first.
- R5: With `modeSel`=4 the line always inverts at the cell start. It inverts again at mid-cell only for a 1.
- R6: With `modeSel`=5 the line always inverts at the cell start. It inverts again at mid-cell only for a 0.
- R7: With `modeSel`=6 the line is high then low for a 1, and low then high for a 0.
- R8: With `modeSel`=7 every cell has a mid-cell edge. For a 1 its direction is the opposite of the stored last mid-cell edge; for a 0 it is the same. The first-half level is set so that this edge occurs. Only cells in this mode update the stored edge.
- R9: The code selector and the data bit are captured only in the strobe cycle. Changes to them during the second half do not affect that cell.
- R10: The line changes on the edge that ends the strobe cycle, gives the second-half level on the following edge, and then holds while no strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 1 | Data bit, captured in the strobe cycle |
| bitStrobe | input | 1 | High for one clock at the start of each cell |
| modeSel | input | 3 | Line code selector, captured in the strobe cycle |
| lineOut | output | 1 | Encoded line level |

## Verification
Each code is driven with a mixed bit pattern that starts from a known line level, so that runs of equal bits and alternations are both seen. That separates codes which act on the bit value from codes which act on the previous level. The differential code is run first straight after reset and then after cells of other modes. This shows whether the stored edge direction starts as falling and whether other modes leave it alone. Separate cells change the selector and the data bit in the second half, and idle gaps with no strobe check that the line holds.

// File: rtl/lineEncoderPkg.sv
package lineEncoderPkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NRZ    = 3'd0,
    MODE_NRZB   = 3'd1,
    MODE_NRZIM  = 3'd2,
    MODE_NRZIS  = 3'd3,
    MODE_BIM    = 3'd4,
    MODE_BIS    = 3'd5,
    MODE_BIL    = 3'd6,
    MODE_DBIL   = 3'd7
  } lineMode_e;

  typedef struct packed {
    logic      loadFirst;
    logic      loadSecond;
    lineMode_e mode;
    logic      dataBit;
  } cellCtl_t;
endpackage

// File: rtl/lineEncoderCtl.sv
module lineEncoderCtl
  import lineEncoderPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                dataIn,
  input  logic                bitStrobe,
  input  logic [MODE_W-1:0]   modeSel,
  output cellCtl_t            ctl
);
  logic      halfPending;
  lineMode_e cellMode;
  logic      cellData;

  always_ff @(posedge clk) begin
    if (rst) begin
      halfPending <= 1'b0;
      cellMode    <= MODE_NRZ;
      cellData    <= 1'b0;
    end else begin
      halfPending <= bitStrobe;
      if (bitStrobe) begin
        cellMode <= lineMode_e'(modeSel);
        cellData <= dataIn;
      end
    end
  end

  always_comb begin
    ctl.loadFirst  = bitStrobe;
    ctl.loadSecond = halfPending && !bitStrobe;
    ctl.mode       = bitStrobe ? lineMode_e'(modeSel) : cellMode;
    ctl.dataBit    = bitStrobe ? dataIn : cellData;
  end

  // R9: the second half uses the mode and bit captured in the strobe cycle
  a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
    ctl.loadSecond |-> (ctl.mode == $past(ctl.mode) && ctl.dataBit == $past(ctl.dataBit)));
endmodule

// File: rtl/lineEncoderDp.sv
module lineEncoderDp
  import lineEncoderPkg::*;
#(
  parameter bit RESET_LEVEL = 1'b0
)(
  input  logic     clk,
  input  logic     rst,
  input  cellCtl_t ctl,
  output logic     lineOut
);
  logic lastMidRise;
  logic firstLevel;
  logic secondLevel;
  logic diffRise;

  // mid-cell edge direction for the differential code
  assign diffRise = ctl.dataBit ? !lastMidRise : lastMidRise;

  always_comb begin
    case (ctl.mode)
      MODE_NRZ:   firstLevel = ctl.dataBit;
      MODE_NRZB:  firstLevel = !ctl.dataBit;
      MODE_NRZIM: firstLevel = ctl.dataBit ? !lineOut : lineOut;
      MODE_NRZIS: firstLevel = ctl.dataBit ? lineOut : !lineOut;
      MODE_BIM,
      MODE_BIS:   firstLevel = !lineOut;
      MODE_BIL:   firstLevel = ctl.dataBit;
      MODE_DBIL:  firstLevel = !diffRise;
      default:    firstLevel = lineOut;
    endcase
  end

  always_comb begin
    case (ctl.mode)
      MODE_BIM:  secondLevel = ctl.dataBit ? !lineOut : lineOut;
      MODE_BIS:  secondLevel = ctl.dataBit ? lineOut : !lineOut;
      MODE_BIL,
      MODE_DBIL: secondLevel = !lineOut;
      default:   secondLevel = lineOut;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineOut     <= RESET_LEVEL;
      lastMidRise <= 1'b0;
    end else if (ctl.loadFirst) begin
      lineOut <= firstLevel;
    end else if (ctl.loadSecond) begin
      lineOut <= secondLevel;
      if (ctl.mode == MODE_DBIL) lastMidRise <= !lineOut;
    end
  end

  // R10: no strobe activity leaves the line untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadFirst && !ctl.loadSecond) |=> $stable(lineOut));
  // R5 / R6: biphase mark and space always flip at the cell start
  a_r5_bim_start_edge: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadFirst && (ctl.mode == MODE_BIM || ctl.mode == MODE_BIS)) |=> (lineOut != $past(lineOut)));
  // R3: NRZI mark flips for a one
  a_r3_nrzim_one_flips: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadFirst && ctl.mode == MODE_NRZIM && ctl.dataBit) |=> (lineOut != $past(lineOut)));
  // R7: biphase level always has a mid-cell edge
  a_r7_bil_mid_edge: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadSecond && ctl.mode == MODE_BIL) |=> (lineOut != $past(lineOut)));
  // R8: differential biphase always has a mid-cell edge
  a_r8_dbil_mid_edge: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadSecond && ctl.mode == MODE_DBIL) |=> (lineOut != $past(lineOut)));
  // R2: NRZ keeps the bit value on the line through both halves
  a_r2_nrz_level: assert property (@(posedge clk) disable iff (rst)
    ((ctl.loadFirst || ctl.loadSecond) && ctl.mode == MODE_NRZ) |=> (lineOut == $past(ctl.dataBit)));
endmodule

// File: rtl/lineEncoderTop.sv
module lineEncoderTop
  import lineEncoderPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic              bitStrobe,
  input  logic [2:0]        modeSel,
  output logic              lineOut
);
  cellCtl_t ctl;

  lineEncoderCtl uCtl (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .bitStrobe (bitStrobe),
    .modeSel   (modeSel),
    .ctl       (ctl)
  );

  lineEncoderDp #(.RESET_LEVEL(1'b0)) uDp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .lineOut (lineOut)
  );
endmodule

// File: tb/tb_lineEncoderTop.sv
module tb_lineEncoderTop;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic bitStrobe = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic lineOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // bench-side history, maintained from the requirements
  logic expLine = 1'b0;
  logic expRise = 1'b0;

  lineEncoderTop dut (
    .clk(clk), .rst(rst), .dataIn(dataIn),
    .bitStrobe(bitStrobe), .modeSel(modeSel), .lineOut(lineOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: lineOut=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expectCell(input logic [2:0] m, input logic d,
                            output logic e1, output logic e2);
    logic r;
    case (m)
      3'd0: begin e1 = d;  e2 = d; end
      3'd1: begin e1 = !d; e2 = !d; end
      3'd2: begin e1 = d ? !expLine : expLine; e2 = e1; end
      3'd3: begin e1 = d ? expLine : !expLine; e2 = e1; end
      3'd4: begin e1 = !expLine; e2 = d ? !e1 : e1; end
      3'd5: begin e1 = !expLine; e2 = d ? e1 : !e1; end
      3'd6: begin e1 = d;  e2 = !d; end
      default: begin
        r = d ? !expRise : expRise;
        e1 = !r; e2 = r; expRise = r;
      end
    endcase
    expLine = e2;
  endtask

  // one cell; optionally disturb selector and bit during the second half
  task automatic sendCell(input string req, input logic [2:0] m, input logic d,
                          input bit disturb);
    logic e1, e2;
    expectCell(m, d, e1, e2);
    @(negedge clk);
    bitStrobe = 1'b1; dataIn = d; modeSel = m;
    @(negedge clk);
    check(req, lineOut, e1);
    bitStrobe = 1'b0;
    if (disturb) begin dataIn = !d; modeSel = m ^ 3'd3; end
    @(negedge clk);
    check(req, lineOut, e2);
  endtask

  task automatic sendPattern(input string req, input logic [2:0] m, input logic [7:0] bits);
    for (int i = 7; i >= 0; i--) sendCell(req, m, bits[i], 1'b0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset level", lineOut, 1'b0);
    rst = 1'b0;
    expLine = 1'b0; expRise = 1'b0;
    // first differential cell after reset exposes the stored falling edge
    sendCell("R1 reset edge", 3'd7, 1'b1, 1'b0);
    sendCell("R1 reset edge", 3'd7, 1'b0, 1'b0);
  endtask

  task automatic testNrz();
    sendPattern("R2 nrz", 3'd0, 8'b1100_1010);
    sendPattern("R2 nrzb", 3'd1, 8'b1001_1101);
  endtask

  task automatic testNrzi();
    sendPattern("R3 nrzi mark", 3'd2, 8'b1110_0101);
    sendPattern("R4 nrzi space", 3'd3, 8'b0001_1010);
  endtask

  task automatic testBiphase();
    sendPattern("R5 biphase mark", 3'd4, 8'b1101_0011);
    sendPattern("R6 biphase space", 3'd5, 8'b0010_1100);
    sendPattern("R7 biphase level", 3'd6, 8'b1011_0001);
  endtask

  task automatic testDiff();
    sendPattern("R8 diff biphase", 3'd7, 8'b1101_0010);
    // other modes must not disturb the stored edge
    sendPattern("R8 interleave", 3'd4, 8'b0110_0000);
    sendPattern("R8 after other", 3'd7, 8'b0011_1011);
  endtask

  task automatic testCapture();
    for (int m = 0; m < 8; m++) begin
      sendCell("R9 capture", 3'(m), 1'b1, 1'b1);
      sendCell("R9 capture", 3'(m), 1'b0, 1'b1);
    end
  endtask

  task automatic testIdle();
    sendCell("R10 timing", 3'd6, 1'b1, 1'b0);
    dataIn = 1'b1; modeSel = 3'd1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 idle hold", lineOut, expLine);
    end
    sendCell("R10 after idle", 3'd2, 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    testReset();
    testNrz();
    testNrzi();
    testBiphase();
    testDiff();
    testCapture();
    testIdle();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule